// File: doc/BRIEF.md
# Physical Register Reclamation Tracker

This block keeps, for every physical register of a renaming core, the three pieces of state that decide when the register may return to the free pool. The three pieces are a written flag, a released flag and a small count of pending source reads. A register becomes reusable only when all three agree: its value has been produced, no architected name still points at it, and no issued instruction still has to read it. The block reports the full reusable set as a bit vector. It also offers one register to the allocator, picked by a lowest-index priority encoder.

Fetch can raise the pending-read count of any register from up to four source operands in one cycle. Operand fetch lowers it from up to four read ports. Write-back sets the written flag, and a remap event sets the released flag. An allocate pulse takes the offered register and clears both flags. On a branch mispredict, a recovery strobe comes with a membership vector of the restored map. Every register outside that map is forced reusable. Every register inside it is marked as mapped again.

Top module: `preg_reclaim`

## Requirements
- R1: A register is reported reclaimable exactly when its written flag is set, its released flag is set and its pending-read count is zero.
- R2: After reset, registers 0 to 31 are written, not released, with a count of zero, so they are not reclaimable. Registers 32 to 63 are written, released and at count zero, so they are reclaimable. The offered register is 32, with freeValid high.
- R3: An allocTake pulse while freeValid is high clears both flags of the offered register, which leaves the reclaimable set. An allocTake pulse while freeValid is low changes nothing.
- R4: A write-back on any write port sets the written flag of the indexed register.
- R5: A release event on any release port sets the released flag of the indexed register.
- R6: In one cycle, the count of a register rises by the number of valid increment ports that name it (0 to 4). It falls by the number of valid decrement ports that name it (0 to 4).
- R7: A register that receives equal numbers of increments and decrements in one cycle keeps its count.
- R8: The 4-bit count saturates. It stays at 15 rather than wrapping up, and stays at 0 rather than wrapping down.
- R9: When recover is high, each register whose restoreMap bit is 0 gets both flags set and its count cleared. Each register whose bit is 1 has its released flag cleared, with its written flag and count held. Recovery overrides every other event in that cycle, including allocation.
- R10: freeIdx is the lowest index in the reclaimable vector, and freeValid is high exactly when that vector is nonzero. Both stay stable until the state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| allocTake | input | 1 | Take the offered free register |
| wbValid | input | 2 | Write-back port valids |
| wbIdx | input | 2x6 | Write-back register indices |
| unmapValid | input | 2 | Release port valids |
| unmapIdx | input | 2x6 | Released register indices |
| incValid | input | 4 | Source-read increment valids from fetch |
| incIdx | input | 4x6 | Increment register indices |
| decValid | input | 4 | Read-done decrement valids from operand fetch |
| decIdx | input | 4x6 | Decrement register indices |
| recover | input | 1 | Mispredict recovery strobe |
| restoreMap | input | 64 | 1 = register present in the restored map |
| reclaimable | output | 64 | Per-register reusable bit |
| freeIdx | output | 6 | Lowest reclaimable register |
| freeValid | output | 1 | At least one register is reclaimable |

## Verification
A wrong flag or count can only be seen through the reclaimable vector and the offered register. It becomes visible in the cycle after the event that should have made the register reusable: the bit fails to rise, or freeIdx points at a higher register. A wrapped or mis-summed count stays hidden until the matching decrements drain it, so the tests load counts through several ports at once and then drain them one step at a time. Recovery errors show on the first sample after the strobe, as reusable bits that disagree with the restore vector.

// File: rtl/rclm_pkg.sv
package rclm_pkg;
  localparam int NUM_PHYS  = 64;
  localparam int NUM_ARCH  = 32;
  localparam int IDX_W     = $clog2(NUM_PHYS);
  localparam int CNT_W     = 4;
  localparam int NUM_INC   = 4;
  localparam int NUM_DEC   = 4;
  localparam int NUM_WB    = 2;
  localparam int NUM_UNMAP = 2;
  localparam int MAX_REQ   = (NUM_INC > NUM_DEC) ? NUM_INC : NUM_DEC;
  localparam int REQ_W     = $clog2(MAX_REQ + 1);

  // strobes from control to per-register state
  typedef struct packed {
    logic                                recover;
    logic [NUM_PHYS-1:0]                 keep;
    logic [NUM_PHYS-1:0]                 alloc;
    logic [NUM_PHYS-1:0]                 wb;
    logic [NUM_PHYS-1:0]                 unmap;
    logic [NUM_PHYS-1:0][REQ_W-1:0]      incN;
    logic [NUM_PHYS-1:0][REQ_W-1:0]      decN;
  } strobe_t;
endpackage

// File: rtl/rclm_ctrl.sv
module rclm_ctrl
  import rclm_pkg::*;
(
  input  logic                               allocTake,
  input  logic [NUM_WB-1:0]                  wbValid,
  input  logic [NUM_WB-1:0][IDX_W-1:0]       wbIdx,
  input  logic [NUM_UNMAP-1:0]               unmapValid,
  input  logic [NUM_UNMAP-1:0][IDX_W-1:0]    unmapIdx,
  input  logic [NUM_INC-1:0]                 incValid,
  input  logic [NUM_INC-1:0][IDX_W-1:0]      incIdx,
  input  logic [NUM_DEC-1:0]                 decValid,
  input  logic [NUM_DEC-1:0][IDX_W-1:0]      decIdx,
  input  logic                               recover,
  input  logic [NUM_PHYS-1:0]                restoreMap,
  input  logic [NUM_PHYS-1:0]                reclaimable,
  output strobe_t                            strobe,
  output logic [IDX_W-1:0]                   freeIdx,
  output logic                               freeValid
);
  // lowest-index priority encoder over the reusable set
  always_comb begin
    freeIdx   = '0;
    freeValid = 1'b0;
    for (int p = NUM_PHYS - 1; p >= 0; p--) begin
      if (reclaimable[p]) begin
        freeIdx   = IDX_W'(p);
        freeValid = 1'b1;
      end
    end
  end

  always_comb begin
    strobe.recover = recover;
    strobe.keep    = restoreMap;
    for (int p = 0; p < NUM_PHYS; p++) begin
      strobe.alloc[p] = allocTake && freeValid && (freeIdx == IDX_W'(p));
      strobe.wb[p]    = 1'b0;
      strobe.unmap[p] = 1'b0;
      strobe.incN[p]  = '0;
      strobe.decN[p]  = '0;
      for (int k = 0; k < NUM_WB; k++)
        if (wbValid[k] && wbIdx[k] == IDX_W'(p)) strobe.wb[p] = 1'b1;
      for (int k = 0; k < NUM_UNMAP; k++)
        if (unmapValid[k] && unmapIdx[k] == IDX_W'(p)) strobe.unmap[p] = 1'b1;
      for (int k = 0; k < NUM_INC; k++)
        if (incValid[k] && incIdx[k] == IDX_W'(p)) strobe.incN[p] = strobe.incN[p] + REQ_W'(1);
      for (int k = 0; k < NUM_DEC; k++)
        if (decValid[k] && decIdx[k] == IDX_W'(p)) strobe.decN[p] = strobe.decN[p] + REQ_W'(1);
    end
  end
endmodule

// File: rtl/rclm_state.sv
module rclm_state
  import rclm_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  strobe_t                        strobe,
  output logic [NUM_PHYS-1:0]            reclaimable,
  output logic [NUM_PHYS-1:0][CNT_W-1:0] cnt
);
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic [NUM_PHYS-1:0] complete;
  logic [NUM_PHYS-1:0] released;

  for (genvar p = 0; p < NUM_PHYS; p++) begin : g_reg
    localparam logic RST_REL = (p >= NUM_ARCH);
    logic [CNT_W-1:0] cntNext;

    // saturating multi-input up/down count
    always_comb begin
      int sum;
      sum = int'(cnt[p]) + int'(strobe.incN[p]) - int'(strobe.decN[p]);
      if (sum < 0)            cntNext = '0;
      else if (sum > CNT_MAX) cntNext = CNT_W'(CNT_MAX);
      else                    cntNext = CNT_W'(sum);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        complete[p] <= 1'b1;
        released[p] <= RST_REL;
        cnt[p]      <= '0;
      end else if (strobe.recover) begin
        if (strobe.keep[p]) begin
          released[p] <= 1'b0;
        end else begin
          complete[p] <= 1'b1;
          released[p] <= 1'b1;
          cnt[p]      <= '0;
        end
      end else begin
        if (strobe.alloc[p]) begin
          complete[p] <= 1'b0;
          released[p] <= 1'b0;
        end else begin
          if (strobe.wb[p])    complete[p] <= 1'b1;
          if (strobe.unmap[p]) released[p] <= 1'b1;
        end
        cnt[p] <= cntNext;
      end
    end

    assign reclaimable[p] = complete[p] && released[p] && (cnt[p] == '0);
  end
endmodule

// File: rtl/preg_reclaim.sv
module preg_reclaim
  import rclm_pkg::*;
(
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               allocTake,
  input  logic [NUM_WB-1:0]                  wbValid,
  input  logic [NUM_WB-1:0][IDX_W-1:0]       wbIdx,
  input  logic [NUM_UNMAP-1:0]               unmapValid,
  input  logic [NUM_UNMAP-1:0][IDX_W-1:0]    unmapIdx,
  input  logic [NUM_INC-1:0]                 incValid,
  input  logic [NUM_INC-1:0][IDX_W-1:0]      incIdx,
  input  logic [NUM_DEC-1:0]                 decValid,
  input  logic [NUM_DEC-1:0][IDX_W-1:0]      decIdx,
  input  logic                               recover,
  input  logic [NUM_PHYS-1:0]                restoreMap,
  output logic [NUM_PHYS-1:0]                reclaimable,
  output logic [IDX_W-1:0]                   freeIdx,
  output logic                               freeValid
);
  strobe_t                        strobe;
  logic [NUM_PHYS-1:0][CNT_W-1:0] cnt;

  rclm_ctrl u_ctrl (
    .allocTake  (allocTake),
    .wbValid    (wbValid),
    .wbIdx      (wbIdx),
    .unmapValid (unmapValid),
    .unmapIdx   (unmapIdx),
    .incValid   (incValid),
    .incIdx     (incIdx),
    .decValid   (decValid),
    .decIdx     (decIdx),
    .recover    (recover),
    .restoreMap (restoreMap),
    .reclaimable(reclaimable),
    .strobe     (strobe),
    .freeIdx    (freeIdx),
    .freeValid  (freeValid)
  );

  rclm_state u_state (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reclaimable(reclaimable),
    .cnt        (cnt)
  );
endmodule

// File: rtl/preg_reclaim_chk.sv
module preg_reclaim_chk
  import rclm_pkg::*;
(
  input logic                           clk,
  input logic                           rstN,
  input logic                           allocTake,
  input logic                           recover,
  input logic [NUM_PHYS-1:0]            restoreMap,
  input logic [NUM_PHYS-1:0]            reclaimable,
  input logic [IDX_W-1:0]               freeIdx,
  input logic                           freeValid,
  input logic [NUM_PHYS-1:0][CNT_W-1:0] cnt,
  input logic [NUM_PHYS-1:0][REQ_W-1:0] incN,
  input logic [NUM_PHYS-1:0][REQ_W-1:0] decN
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  p_free_is_reclaimable_r10: assert property (@(posedge clk) disable iff (!rstN)
    freeValid |-> reclaimable[freeIdx]);

  p_free_lowest_r10: assert property (@(posedge clk) disable iff (!rstN)
    freeValid |-> ((reclaimable & ((NUM_PHYS'(1) << freeIdx) - NUM_PHYS'(1))) == '0));

  p_alloc_consumes_r3: assert property (@(posedge clk) disable iff (!rstN)
    (allocTake && freeValid && !recover) |=> !reclaimable[$past(freeIdx)]);

  p_recover_absent_r9: assert property (@(posedge clk) disable iff (!rstN)
    recover |=> ((~reclaimable & ~$past(restoreMap)) == '0));

  p_recover_present_r9: assert property (@(posedge clk) disable iff (!rstN)
    recover |=> ((reclaimable & $past(restoreMap)) == '0));

  for (genvar p = 0; p < NUM_PHYS; p++) begin : g_cnt
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
      (cnt[p] == CMAX && incN[p] > decN[p] && !recover) |=> cnt[p] == CMAX);
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rstN)
      (cnt[p] == '0 && decN[p] > incN[p] && !recover) |=> cnt[p] == '0);
  end
endmodule

bind preg_reclaim preg_reclaim_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .allocTake  (allocTake),
  .recover    (recover),
  .restoreMap (restoreMap),
  .reclaimable(reclaimable),
  .freeIdx    (freeIdx),
  .freeValid  (freeValid),
  .cnt        (cnt),
  .incN       (strobe.incN),
  .decN       (strobe.decN)
);

// File: tb/sim_preg_reclaim.sv
`timescale 1ns/1ps
module sim_preg_reclaim;
  import rclm_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allocTake;
  logic [NUM_WB-1:0] wbValid;
  logic [NUM_WB-1:0][IDX_W-1:0] wbIdx;
  logic [NUM_UNMAP-1:0] unmapValid;
  logic [NUM_UNMAP-1:0][IDX_W-1:0] unmapIdx;
  logic [NUM_INC-1:0] incValid;
  logic [NUM_INC-1:0][IDX_W-1:0] incIdx;
  logic [NUM_DEC-1:0] decValid;
  logic [NUM_DEC-1:0][IDX_W-1:0] decIdx;
  logic recover;
  logic [NUM_PHYS-1:0] restoreMap;
  logic [NUM_PHYS-1:0] reclaimable;
  logic [IDX_W-1:0] freeIdx;
  logic freeValid;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  preg_reclaim u0 (.*);

  typedef enum logic [2:0] {OP_NOP, OP_ALLOC, OP_WB, OP_UNMAP, OP_INC, OP_DEC, OP_INCDEC} op_e;
  typedef struct packed {
    logic [2:0] op;
    logic [5:0] idx;
    logic [5:0] watch;
    logic       expRec;
    logic [5:0] expFree;
    logic       expValid;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 6'd0,  6'd32, 1'b1, 6'd32, 1'b1, 4'd2},  // R2 idle after reset
    '{3'd1, 6'd0,  6'd32, 1'b0, 6'd33, 1'b1, 4'd3},  // R3 allocate 32
    '{3'd4, 6'd32, 6'd32, 1'b0, 6'd33, 1'b1, 4'd6},  // R6 one pending read
    '{3'd2, 6'd32, 6'd32, 1'b0, 6'd33, 1'b1, 4'd4},  // R4 written
    '{3'd3, 6'd32, 6'd32, 1'b0, 6'd33, 1'b1, 4'd1},  // R1 read still pending
    '{3'd5, 6'd32, 6'd32, 1'b1, 6'd32, 1'b1, 4'd1},  // R1 all three met, R10 lowest
    '{3'd3, 6'd5,  6'd5,  1'b1, 6'd5,  1'b1, 4'd5},  // R5 release mapped reg 5
    '{3'd1, 6'd0,  6'd5,  1'b0, 6'd32, 1'b1, 4'd3},  // R3 allocate 5
    '{3'd6, 6'd32, 6'd32, 1'b1, 6'd32, 1'b1, 4'd7},  // R7 balanced inc/dec
    '{3'd2, 6'd7,  6'd7,  1'b0, 6'd32, 1'b1, 4'd4}   // R4 write alone not enough
  };

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    allocTake = 1'b0; wbValid = '0; wbIdx = '0; unmapValid = '0; unmapIdx = '0;
    incValid = '0; incIdx = '0; decValid = '0; decIdx = '0;
    recover = 1'b0; restoreMap = '0;
  endtask

  task automatic tick(); @(negedge clk); idle(); endtask

  task automatic incMany(input int idx, input int n);
    for (int k = 0; k < n; k++) begin incValid[k] = 1'b1; incIdx[k] = IDX_W'(idx); end
    tick();
  endtask

  task automatic decMany(input int idx, input int n);
    for (int k = 0; k < n; k++) begin decValid[k] = 1'b1; decIdx[k] = IDX_W'(idx); end
    tick();
  endtask

  task automatic unmapOne(input int idx, input int port);
    unmapValid[port] = 1'b1; unmapIdx[port] = IDX_W'(idx);
    tick();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    nRun++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int nAlloc;
    idle();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R2 reset state
    chk(reclaimable == {32'hFFFF_FFFF, 32'h0}, "R2 reset vector", reclaimable, {32'hFFFF_FFFF, 32'h0});
    chk(freeValid && freeIdx == 6'd32, "R2 reset free", {freeValid, freeIdx}, {1'b1, 6'd32});

    // table walk
    for (int v = 0; v < NV; v++) begin
      case (op_e'(VECS[v].op))
        OP_ALLOC:  allocTake = 1'b1;
        OP_WB:     begin wbValid[0] = 1'b1; wbIdx[0] = VECS[v].idx; end
        OP_UNMAP:  begin unmapValid[0] = 1'b1; unmapIdx[0] = VECS[v].idx; end
        OP_INC:    begin incValid[0] = 1'b1; incIdx[0] = VECS[v].idx; end
        OP_DEC:    begin decValid[0] = 1'b1; decIdx[0] = VECS[v].idx; end
        OP_INCDEC: begin incValid[0] = 1'b1; incIdx[0] = VECS[v].idx;
                         decValid[0] = 1'b1; decIdx[0] = VECS[v].idx; end
        default: ;
      endcase
      tick();
      chk(reclaimable[VECS[v].watch] == VECS[v].expRec,
          $sformatf("R%0d vec%0d reclaim", VECS[v].req, v), reclaimable[VECS[v].watch], VECS[v].expRec);
      chk({freeValid, freeIdx} == {VECS[v].expValid, VECS[v].expFree},
          $sformatf("R%0d vec%0d free", VECS[v].req, v), {freeValid, freeIdx}, {VECS[v].expValid, VECS[v].expFree});
    end

    // R6 four increments in one cycle, drained by 3 then 1
    incMany(10, 4);
    unmapOne(10, 1);
    chk(!reclaimable[10], "R6 count four pending", reclaimable[10], 0);
    decMany(10, 3);
    chk(!reclaimable[10], "R6 count one pending", reclaimable[10], 0);
    decMany(10, 1);
    chk(reclaimable[10] && freeIdx == 6'd10, "R6 drained", {reclaimable[10], freeIdx}, {1'b1, 6'd10});

    // R8 saturation at 15: 20 increments hold 15, 12 decrements leave 3
    for (int i = 0; i < 5; i++) incMany(11, 4);
    unmapOne(11, 0);
    for (int i = 0; i < 3; i++) decMany(11, 4);
    chk(!reclaimable[11], "R8 saturated high", reclaimable[11], 0);
    decMany(11, 3);
    chk(reclaimable[11], "R8 drained from 15", reclaimable[11], 1);

    // R8 floor at 0
    unmapOne(12, 0);
    decMany(12, 2);
    incMany(12, 1);
    chk(!reclaimable[12], "R8 inc after floor", reclaimable[12], 0);
    decMany(12, 1);
    chk(reclaimable[12], "R8 floor held at zero", reclaimable[12], 1);

    // R9 recovery, overriding a same-cycle allocation of 12
    allocTake = 1'b1; tick();                        // take 10
    allocTake = 1'b1; tick();                        // take 11
    chk(freeIdx == 6'd12, "R10 next offered", freeIdx, 12);
    incMany(33, 1);
    chk(!reclaimable[33], "R1 free reg with pending read", reclaimable[33], 0);
    restoreMap = '0;
    for (int i = 0; i < 32; i++) restoreMap[i] = 1'b1;
    restoreMap[10] = 1'b0; restoreMap[12] = 1'b0; restoreMap[40] = 1'b1;
    recover = 1'b1; allocTake = 1'b1;
    tick();
    chk(reclaimable[10], "R9 absent forced", reclaimable[10], 1);
    chk(!reclaimable[11], "R9 present not reusable", reclaimable[11], 0);
    chk(reclaimable[12], "R9 overrides allocate", reclaimable[12], 1);
    chk(!reclaimable[40], "R9 present remapped", reclaimable[40], 0);
    chk(reclaimable[33], "R9 count cleared", reclaimable[33], 1);
    chk(freeIdx == 6'd10 && freeValid, "R10 after recover", freeIdx, 10);

    // R3/R10 exhaustion: 10, 12 and 32..63 without 40 = 33 registers
    nAlloc = 0;
    while (freeValid && nAlloc < 70) begin
      allocTake = 1'b1; tick(); nAlloc++;
    end
    chk(nAlloc == 33, "R3 allocations to empty", nAlloc, 33);
    chk(!freeValid && reclaimable == '0, "R10 empty pool", reclaimable, 0);
    allocTake = 1'b1; tick();
    chk(!freeValid && reclaimable == '0, "R3 allocate ignored when empty", freeValid, 0);
    unmapOne(40, 1);
    chk(freeValid && freeIdx == 6'd40, "R5 release refills pool", {freeValid, freeIdx}, {1'b1, 6'd40});
    repeat (2) tick();
    chk(freeValid && freeIdx == 6'd40, "R10 stable while untaken", freeIdx, 40);

    finishRun();
  end
endmodule